// File: doc/BRIEF.md
# Programmable horizontal line timing sequencer

This block produces the horizontal timing of one display line. A free-running pixel-clock counter climbs from zero to a programmed line total and then restarts. Software loads a set of absolute threshold values through a simple write port. On every clock edge at which the counter equals one of them, the sequencer switches into a new mode: sync, back porch, left border, active image, right border or front porch. The mode drives four outputs. These are a sync pulse, a pixel-fetch request, a border-colour select and a blank flag.

Line segments are not measured as widths. They are edges at absolute positions. When several thresholds land on the same counter value, a fixed precedence picks the winning mode. A threshold set in the wrong order therefore shrinks or suppresses a segment in a defined way rather than producing undefined behaviour. All thresholds are copied into working registers as the counter returns to zero, so a write made in the middle of a line only affects the next line. A sticky flag reports a programmed back porch or front porch that is shorter than the panel tolerates.

Top module: `hline_seq`

## Requirements
- R1: The counter steps by one per clock from 0 up to the working line total, then returns to 0. A line therefore lasts total+1 clocks, and successive rising edges of `hsync` are total+1 clocks apart.
- R2: On the clock edge at which the counter equals a working threshold, the matching mode is latched. Outputs show the new mode from the following cycle. With the thresholds in their intended order, a line runs front porch, sync, back porch, left border, image, right border and back to front porch.
- R3: Output encoding per mode. `hsync`=1 only in sync. `pix_req`=1 only in image. `border_sel`=1 only in left or right border. `blank`=1 in sync, back porch and front porch.
- R4: Write offsets. 0x10 holds the sync threshold, 0x14 back porch, 0x18 left border, 0x64 front porch and 0x68 line total, each in bits 15:0. 0x60 holds image start in bits 15:0 and image end in bits 31:16. Other offsets are ignored.
- R5: When several thresholds match on the same cycle, the order from highest to lowest is: back porch, sync, image end, image start, left border, front porch. The losing matches are discarded, except as stated in R7.
- R6: If the back-porch threshold equals the sync threshold, back porch wins and `hsync` never rises.
- R7: Only a back-porch match leaves sync mode. A left-border match is held pending in these cases: it arrives in sync or front porch, or it coincides with a back-porch match. When back porch is then entered, the left border starts on that same edge, so the back porch lasts zero cycles and `hsync` is followed directly by `border_sel`.
- R8: Threshold writes are copied to the working set only as the counter returns to 0. A write made in the middle of a line does not change the current line and takes effect from the next line.
- R9: At each line start, `porch_err` is set and stays set if either of these holds for the working values. The back porch (left border minus back porch, or 0 if left border lies below back porch) is under 16 clocks. Or the front porch (total+1 minus front porch plus sync) is under 68 clocks.
- R10: Any register write clears `porch_err` on the following cycle, and the write takes precedence over a set on the same edge.
- R11: While `rst` is high, `hsync`, `pix_req`, `border_sel` and `porch_err` are 0 and `blank` is 1.
- R12: If image start equals image end, image end wins, the line goes directly from left border to right border, and `pix_req` stays 0 for the whole line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (8) | Register byte offset |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | High during sync mode |
| pix_req | output | 1 | Pixel fetch request, high during the active image |
| border_sel | output | 1 | Selects the solid border colour |
| blank | output | 1 | High during sync and both porches |
| porch_err | output | 1 | Sticky flag for a porch shorter than its minimum |

## Verification
The bench builds the block with its default parameters. The 12-bit counter and the 16/68-clock porch minimums allow lines of 200 and 250 clocks, which keeps every mode boundary within a short run. With those values the bench can place thresholds so that they collide (back porch on sync, image end on image start) or arrive out of order (left border before sync). Each porch can also be pushed just under its minimum. The line-total register is changed during the run to show that the wrap point moves with it.

// File: rtl/hl_pkg.sv
package hl_pkg;
    localparam int TW = 16;
    localparam int DW = 32;

    localparam logic [7:0] OFS_SYNC  = 8'h10;
    localparam logic [7:0] OFS_BACK  = 8'h14;
    localparam logic [7:0] OFS_LEFT  = 8'h18;
    localparam logic [7:0] OFS_IMG   = 8'h60;
    localparam logic [7:0] OFS_FRONT = 8'h64;
    localparam logic [7:0] OFS_TOTAL = 8'h68;

    typedef enum logic [2:0] {
        MD_FRONT, MD_SYNC, MD_BACK, MD_LEFT, MD_IMAGE, MD_RIGHT
    } mode_t;

    typedef struct packed {
        logic [TW-1:0] sync_at;
        logic [TW-1:0] back_at;
        logic [TW-1:0] left_at;
        logic [TW-1:0] img_on;
        logic [TW-1:0] img_off;
        logic [TW-1:0] front_at;
        logic [TW-1:0] total;
    } thr_t;

    typedef struct packed {
        logic back;
        logic sync;
        logic img_off;
        logic img_on;
        logic left;
        logic front;
    } evt_t;

    // Clocks spent in back porch: left border minus back porch, floored at zero.
    function automatic logic [TW+1:0] back_len(thr_t t);
        if (t.left_at >= t.back_at)
            return {2'b00, t.left_at} - {2'b00, t.back_at};
        return '0;
    endfunction

    // Clocks from the front-porch edge to the next sync edge, across the wrap.
    function automatic logic [TW+1:0] front_len(thr_t t);
        return {2'b00, t.total} + (TW+2)'(1) - {2'b00, t.front_at} + {2'b00, t.sync_at};
    endfunction
endpackage

// File: rtl/hl_regs.sv
module hl_regs
    import hl_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          line_end,
    output thr_t          work
);
    thr_t host;

    always_ff @(posedge clk) begin
        if (rst) begin
            host <= '0;
            work <= '0;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    AW'(OFS_SYNC):  host.sync_at  <= wr_data[TW-1:0];
                    AW'(OFS_BACK):  host.back_at  <= wr_data[TW-1:0];
                    AW'(OFS_LEFT):  host.left_at  <= wr_data[TW-1:0];
                    AW'(OFS_FRONT): host.front_at <= wr_data[TW-1:0];
                    AW'(OFS_TOTAL): host.total    <= wr_data[TW-1:0];
                    AW'(OFS_IMG): begin
                        host.img_on  <= wr_data[TW-1:0];
                        host.img_off <= wr_data[2*TW-1:TW];
                    end
                    default: ;
                endcase
            end
            if (line_end)
                work <= host;
        end
    end

    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> $stable(work));
endmodule

// File: rtl/hl_match.sv
module hl_match
    import hl_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic [CW-1:0] hcnt,
    input  thr_t          work,
    output evt_t          ev
);
    logic [TW-1:0] pos;
    assign pos = TW'(hcnt);

    always_comb begin
        ev.back    = (pos == work.back_at);
        ev.sync    = (pos == work.sync_at);
        ev.img_off = (pos == work.img_off);
        ev.img_on  = (pos == work.img_on);
        ev.left    = (pos == work.left_at);
        ev.front   = (pos == work.front_at);
    end
endmodule

// File: rtl/hl_mode.sv
module hl_mode
    import hl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  evt_t  ev,
    output mode_t mode
);
    mode_t nxt;
    logic  pend, pend_n, hold;

    always_comb begin
        nxt    = mode;
        pend_n = pend;
        hold   = (mode == MD_SYNC) || (mode == MD_FRONT);
        if (ev.back) begin
            nxt    = (pend || ev.left) ? MD_LEFT : MD_BACK;
            pend_n = 1'b0;
        end else begin
            if (ev.left && hold)
                pend_n = 1'b1;
            if (mode != MD_SYNC) begin
                if (ev.sync)                          nxt = MD_SYNC;
                else if (ev.img_off)                  nxt = MD_RIGHT;
                else if (ev.img_on)                   nxt = MD_IMAGE;
                else if (ev.left && mode == MD_BACK)  nxt = MD_LEFT;
                else if (ev.front)                    nxt = MD_FRONT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MD_FRONT;
            pend <= 1'b0;
        end else begin
            mode <= nxt;
            pend <= pend_n;
        end
    end

    // R7
    sync_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_SYNC && !ev.back) |=> mode == MD_SYNC);
    // R5
    back_first_chk: assert property (@(posedge clk) disable iff (rst)
        ev.back |=> (mode == MD_BACK || mode == MD_LEFT));
    // R7
    pend_take_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && ev.back) |=> mode == MD_LEFT);
    // R12
    off_over_on_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.img_off && !ev.back && !ev.sync && mode != MD_SYNC) |=> mode == MD_RIGHT);
endmodule

// File: rtl/hline_seq.sv
module hline_seq
    import hl_pkg::*;
#(
    parameter int CW        = 12,
    parameter int AW        = 8,
    parameter int MIN_BACK  = 16,
    parameter int MIN_FRONT = 68
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [31:0]   wr_data,
    output logic          hsync,
    output logic          pix_req,
    output logic          border_sel,
    output logic          blank,
    output logic          porch_err
);
    localparam logic [TW+1:0] BACK_MIN  = (TW+2)'(MIN_BACK);
    localparam logic [TW+1:0] FRONT_MIN = (TW+2)'(MIN_FRONT);

    logic [CW-1:0] hcnt;
    logic          line_end;
    logic          too_short;
    thr_t          work;
    evt_t          ev;
    mode_t         mode;

    assign line_end  = (TW'(hcnt) == work.total);
    assign too_short = (back_len(work) < BACK_MIN) || (front_len(work) < FRONT_MIN);

    hl_regs #(.AW(AW)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .line_end (line_end),
        .work     (work)
    );

    hl_match #(.CW(CW)) match_i (
        .hcnt (hcnt),
        .work (work),
        .ev   (ev)
    );

    hl_mode mode_i (
        .clk  (clk),
        .rst  (rst),
        .ev   (ev),
        .mode (mode)
    );

    always_ff @(posedge clk) begin
        if (rst)           hcnt <= '0;
        else if (line_end) hcnt <= '0;
        else               hcnt <= hcnt + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)                             porch_err <= 1'b0;
        else if (wr_en)                      porch_err <= 1'b0;
        else if (hcnt == '0 && too_short)    porch_err <= 1'b1;
    end

    assign hsync      = (mode == MD_SYNC);
    assign pix_req    = (mode == MD_IMAGE);
    assign border_sel = (mode == MD_LEFT) || (mode == MD_RIGHT);
    assign blank      = (mode == MD_SYNC) || (mode == MD_BACK) || (mode == MD_FRONT);

    // R1
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        line_end |=> hcnt == '0);
    // R1
    step_chk: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> hcnt == $past(hcnt) + CW'(1));
    // R10
    err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !porch_err);
endmodule

// File: tb/hline_seq_tb.sv
`timescale 1ns/1ps
module hline_seq_tb_top;
    logic        clk, rst, wr_en;
    logic [7:0]  wr_addr;
    logic [31:0] wr_data;
    logic        hsync, pix_req, border_sel, blank, porch_err;
    int          checks = 0;
    int          errors = 0;

    hline_seq dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync(hsync), .pix_req(pix_req), .border_sel(border_sel),
        .blank(blank), .porch_err(porch_err)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Offsets after the first hsync cycle (counter 5) for sync=4, back=12,
    // left=30, image 40..110, front=120, total=199.
    // Expected bits {hsync, pix_req, border_sel, blank}.
    localparam int N_VEC = 13;
    localparam int VEC_OFF [N_VEC] = '{0, 7, 8, 25, 26, 35, 36, 105, 106, 115, 116, 199, 200};
    localparam logic [3:0] VEC_EXP [N_VEC] = '{
        4'b1001, 4'b1001, 4'b0001, 4'b0001, 4'b0010, 4'b0010, 4'b0100,
        4'b0100, 4'b0010, 4'b0010, 4'b0001, 4'b0001, 4'b1001};

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Returns at the negedge where hsync is first seen high.
    task automatic rise();
        logic prev;
        prev = hsync;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (hsync && !prev) return;
            prev = hsync;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cur, cnt;
        logic p;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        check("R11", "outputs in reset", {hsync, pix_req, border_sel, blank}, 4'b0001);
        check("R11", "flag in reset", porch_err, 0);
        rst = 1'b0;

        wr(8'h10, 4); wr(8'h14, 12); wr(8'h18, 30);
        wr(8'h60, {16'd110, 16'd40}); wr(8'h64, 120); wr(8'h68, 199);
        wr(8'h2C, 32'hFFFF);
        rise(); rise(); rise();
        wr(8'h68, 199);
        rise(); rise();
        check("R9", "legal timing keeps flag low", porch_err, 0);

        // R2 R3 R4 R1: one full line walked from the table
        rise();
        cur = 0;
        for (int i = 0; i < N_VEC; i++) begin
            repeat (VEC_OFF[i] - cur) @(negedge clk);
            cur = VEC_OFF[i];
            check("R2 R3 R4 R1", $sformatf("line offset %0d", cur),
                  {hsync, pix_req, border_sel, blank}, VEC_EXP[i]);
        end

        // R8: image end moved mid-line only applies next line
        rise();
        repeat (50) @(negedge clk);
        wr(8'h60, {16'd90, 16'd40});
        repeat (35) @(negedge clk);
        check("R8", "old image end still active", pix_req, 1);
        rise();
        repeat (86) @(negedge clk);
        check("R8", "new image end applied", {pix_req, border_sel}, 2'b01);
        wr(8'h60, {16'd110, 16'd40});
        rise(); rise();

        // R6 R5: back porch equal to sync suppresses hsync
        wr(8'h14, 4);
        repeat (250) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 450; i++) begin
            @(negedge clk);
            if (hsync) cnt++;
        end
        check("R6 R5", "hsync cycles", cnt, 0);
        wr(8'h14, 12);
        rise(); rise();

        // R7: left border before sync is held, back porch collapses
        wr(8'h18, 2);
        rise(); rise();
        repeat (7) @(negedge clk);
        check("R7", "sync still ends at back porch", hsync, 1);
        @(negedge clk);
        check("R7", "border right after sync", {hsync, pix_req, border_sel, blank}, 4'b0010);
        check("R9", "zero back porch flagged", porch_err, 1);
        wr(8'h18, 30);
        check("R10", "write clears flag", porch_err, 0);
        rise(); rise();
        check("R10", "flag stays low after fix", porch_err, 0);

        // R12 R5: image start equal to image end
        wr(8'h60, {16'd40, 16'd40});
        rise(); rise();
        cnt = 0;
        for (int k = 1; k < 200; k++) begin
            @(negedge clk);
            if (pix_req) cnt++;
            if (k == 36) check("R12", "right border after left", {pix_req, border_sel}, 2'b01);
        end
        check("R12 R5", "pixel request cycles", cnt, 0);
        wr(8'h60, {16'd110, 16'd40});

        // R9: front porch of 54 clocks is too short
        wr(8'h64, 150);
        rise(); rise();
        check("R9", "short front porch flagged", porch_err, 1);
        wr(8'h64, 120);
        rise(); rise();
        check("R10", "flag low after front porch fix", porch_err, 0);

        // R1: new line total moves the wrap point
        wr(8'h68, 249);
        rise(); rise();
        cnt = 0; p = 1'b1;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            cnt++;
            if (hsync && !p) break;
            p = hsync;
        end
        check("R1", "line period", cnt, 250);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule